// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear Commands

This block is a watchdog that counts a dedicated timing tick through a prescaler and a main counter. The processor core forwards its watchdog-clear commands as one-cycle strobes. If the count runs out before a clear arrives, the block either resets the system (while the core is running) or wakes the core (while it is halted). It also keeps the two status flags that the core's status register shows: a time-out flag and a power-down flag.

A static configuration input picks how clearing works. In single mode one plain clear command restarts the count. In paired mode there are two distinct half-clear commands. The count restarts only once both halves have been seen, in either order. A half that arrives alone is held until its partner arrives. The halt command sets the power-down flag, clears the time-out flag and restarts the count, so that a later time-out acts as a wake-up source.

Top module: `wdt_dual_clear`

## Requirements
- R1: While `rst` is sampled high, all four outputs are 0. Once `rst` is released, the count starts from zero.
- R2: The count advances only on cycles where `tick_i` is 1, and idle cycles do not count. A time-out happens on the 2^(PRESC_W+CNT_W)-th tick after the last restart, which is the 128th tick with the defaults PRESC_W=3 and CNT_W=4.
- R3: A time-out while not halted drives `sys_rst_o` to 1 for exactly one cycle, starting at the clock edge that samples the expiring tick. The same edge sets `to_flag_o` to 1. `pd_flag_o` keeps its value, and the count restarts from zero.
- R4: When `dual_mode_i`=0, `clr_i` restarts the count and clears both flags, and `clr_a_i` and `clr_b_i` have no effect.
- R5: When `dual_mode_i`=1, `clr_i` has no effect. The count restarts and both flags clear on the edge where the second of the two distinct halves (`clr_a_i`, `clr_b_i`) is sampled, whichever half came first.
- R6: When `dual_mode_i`=1, a lone half or a repeat of the same half does not restart the count and does not change either flag. The pending half is held, across any number of ticks, until the other half arrives.
- R7: `halt_i` sets `pd_flag_o` to 1, clears `to_flag_o`, restarts the count, enters the halted state and discards any pending half.
- R8: A time-out while halted drives `wake_o` to 1 for exactly one cycle instead of `sys_rst_o`. It also sets `to_flag_o` to 1, keeps `pd_flag_o` at 1 and leaves the halted state.
- R9: A restart (a valid clear or `halt_i`) sampled on the same edge as the expiring tick wins: no time-out pulse is produced, and a full period starts again.
- R10: `sys_rst_o` and `wake_o` are never 1 together, and neither is ever 1 on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tick_i | input | 1 | Watchdog timing tick, one cycle per tick |
| dual_mode_i | input | 1 | 0: single plain clear, 1: paired half-clears |
| clr_i | input | 1 | Plain clear command strobe |
| clr_a_i | input | 1 | First half-clear command strobe |
| clr_b_i | input | 1 | Second half-clear command strobe |
| halt_i | input | 1 | Halt command strobe |
| sys_rst_o | output | 1 | One-cycle system reset request on a running time-out |
| wake_o | output | 1 | One-cycle wake-up on a time-out while halted |
| to_flag_o | output | 1 | Time-out status flag |
| pd_flag_o | output | 1 | Power-down status flag |

## Verification
The properties assume that the core issues at most one command strobe (`clr_i`, `clr_a_i`, `clr_b_i`, `halt_i`) per cycle, and that `dual_mode_i` changes only while `rst` is high. The directed stimulus keeps to both assumptions: every command occupies a cycle of its own, and the mode is switched only inside the reset task. A tick may share a cycle with a command, and the priority test relies on exactly that.

// File: rtl/wdt_dc_pkg.sv
package wdt_dc_pkg;

  // Decoded command events that one cycle can carry.
  typedef struct packed {
    logic halt;   // halt command
    logic clear;  // valid clear (single, or completed pair)
  } wdt_evt_t;

  // Which half of a paired clear is waiting for its partner.
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_A    = 2'd1,
    PEND_B    = 2'd2
  } wdt_pend_e;

endpackage

// File: rtl/wdt_dc_cmd.sv
module wdt_dc_cmd
  import wdt_dc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     dual_mode_i,
  input  logic     clr_i,
  input  logic     clr_a_i,
  input  logic     clr_b_i,
  input  logic     halt_i,
  output wdt_evt_t evt_o
);

  wdt_pend_e pend_q, pend_d;
  logic      pair_done;

  // R5: the pair completes when the missing half arrives, in either order.
  always_comb begin
    pair_done = dual_mode_i &
                ((clr_a_i & ((pend_q == PEND_B) | clr_b_i)) |
                 (clr_b_i &  (pend_q == PEND_A)));
  end

  // R4/R5: the mode decides which command counts as a clear.
  always_comb begin
    evt_o.halt  = halt_i;
    evt_o.clear = ~halt_i & (dual_mode_i ? pair_done : clr_i);
  end

  // R6: a lone half waits; a repeat of the same half keeps waiting.
  always_comb begin
    pend_d = pend_q;
    if (!dual_mode_i || halt_i || pair_done) begin
      pend_d = PEND_NONE;
    end else if (clr_a_i) begin
      pend_d = PEND_A;
    end else if (clr_b_i) begin
      pend_d = PEND_B;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= PEND_NONE;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/wdt_dc_timebase.sv
module wdt_dc_timebase #(
  parameter int unsigned PRESC_W = 3,
  parameter int unsigned CNT_W   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic restart_i,
  output logic expire_o
);

  logic             presc_wrap;
  logic [CNT_W-1:0] cnt_q;

  // R2: the prescaler divides the tick before the main counter sees it.
  generate
    if (PRESC_W > 0) begin : g_presc
      logic [PRESC_W-1:0] presc_q;
      assign presc_wrap = &presc_q;
      always_ff @(posedge clk) begin
        if (rst || restart_i) begin
          presc_q <= '0;
        end else if (tick_i) begin
          presc_q <= presc_q + 1'b1;
        end
      end
    end else begin : g_no_presc
      assign presc_wrap = 1'b1;
    end
  endgenerate

  // Both stages wrap to zero on expiry, which restarts the period (R3).
  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i && presc_wrap) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: a restart in the same cycle cancels the expiry.
  assign expire_o = tick_i & presc_wrap & (&cnt_q) & ~restart_i;

endmodule

// File: rtl/wdt_dc_status.sv
module wdt_dc_status
  import wdt_dc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wdt_evt_t evt_i,
  input  logic     expire_i,
  output logic     sys_rst_o,
  output logic     wake_o,
  output logic     to_flag_o,
  output logic     pd_flag_o
);

  logic halted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      // R1
      sys_rst_o <= 1'b0;
      wake_o    <= 1'b0;
      to_flag_o <= 1'b0;
      pd_flag_o <= 1'b0;
      halted_q  <= 1'b0;
    end else begin
      // R3/R8/R10: one-cycle pulses, picked by the halted state.
      sys_rst_o <= expire_i & ~halted_q;
      wake_o    <= expire_i &  halted_q;
      if (evt_i.halt) begin
        // R7
        pd_flag_o <= 1'b1;
        to_flag_o <= 1'b0;
        halted_q  <= 1'b1;
      end else if (evt_i.clear) begin
        // R4/R5
        pd_flag_o <= 1'b0;
        to_flag_o <= 1'b0;
      end else if (expire_i) begin
        to_flag_o <= 1'b1;
        halted_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wdt_dual_clear.sv
module wdt_dual_clear
  import wdt_dc_pkg::*;
#(
  parameter int unsigned PRESC_W = 3,
  parameter int unsigned CNT_W   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic dual_mode_i,
  input  logic clr_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic halt_i,
  output logic sys_rst_o,
  output logic wake_o,
  output logic to_flag_o,
  output logic pd_flag_o
);

  wdt_evt_t evt;
  logic     restart;
  logic     expire;

  wdt_dc_cmd u_cmd (
    .clk         (clk),
    .rst         (rst),
    .dual_mode_i (dual_mode_i),
    .clr_i       (clr_i),
    .clr_a_i     (clr_a_i),
    .clr_b_i     (clr_b_i),
    .halt_i      (halt_i),
    .evt_o       (evt)
  );

  // R7/R9: a halt restarts the count just as a valid clear does.
  assign restart = evt.halt | evt.clear;

  wdt_dc_timebase #(
    .PRESC_W (PRESC_W),
    .CNT_W   (CNT_W)
  ) u_tb (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .restart_i (restart),
    .expire_o  (expire)
  );

  wdt_dc_status u_st (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt),
    .expire_i  (expire),
    .sys_rst_o (sys_rst_o),
    .wake_o    (wake_o),
    .to_flag_o (to_flag_o),
    .pd_flag_o (pd_flag_o)
  );

endmodule

// File: rtl/wdt_dual_clear_chk.sv
module wdt_dual_clear_chk (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic dual_mode_i,
  input logic clr_i,
  input logic clr_a_i,
  input logic clr_b_i,
  input logic halt_i,
  input logic sys_rst_o,
  input logic wake_o,
  input logic to_flag_o,
  input logic pd_flag_o
);

  logic unused_tick;
  assign unused_tick = tick_i;

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(sys_rst_o && wake_o));

  p_rst_single_r10: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !sys_rst_o);

  p_wake_single_r10: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);

  p_rst_sets_to_r3: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> to_flag_o);

  p_to_rise_src_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(to_flag_o) |-> (sys_rst_o || wake_o));

  p_wake_flags_r8: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (to_flag_o && pd_flag_o));

  p_halt_flags_r7: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> (pd_flag_o && !to_flag_o && !wake_o && !sys_rst_o));

  p_pd_rise_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_flag_o) |-> $past(halt_i));

  p_single_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode_i && clr_i && !halt_i) |=> (!to_flag_o && !pd_flag_o));

  p_plain_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (dual_mode_i && clr_i && !clr_a_i && !clr_b_i && !halt_i) |=>
      ($stable(pd_flag_o) && ($stable(to_flag_o) || sys_rst_o || wake_o)));

endmodule

bind wdt_dual_clear wdt_dual_clear_chk u_chk (.*);

// File: tb/wdt_dual_clear_tb.sv
`timescale 1ns/1ps
module wdt_dual_clear_tb_top;

  localparam int unsigned PERIOD = 128;  // 2^(3+4) ticks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, dual_mode_i = 1'b0;
  logic clr_i = 1'b0, clr_a_i = 1'b0, clr_b_i = 1'b0, halt_i = 1'b0;
  logic sys_rst_o, wake_o, to_flag_o, pd_flag_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  wdt_dual_clear dut_i (
    .clk (clk), .rst (rst), .tick_i (tick_i), .dual_mode_i (dual_mode_i),
    .clr_i (clr_i), .clr_a_i (clr_a_i), .clr_b_i (clr_b_i), .halt_i (halt_i),
    .sys_rst_o (sys_rst_o), .wake_o (wake_o),
    .to_flag_o (to_flag_o), .pd_flag_o (pd_flag_o)
  );

  // Compare all four outputs at once.
  task automatic expect_out(input string req, input logic e_rst, input logic e_wake,
                            input logic e_to, input logic e_pd);
    total++;
    if ({sys_rst_o, wake_o, to_flag_o, pd_flag_o} !== {e_rst, e_wake, e_to, e_pd}) begin
      bad++;
      $display("FAIL %s: rst/wake/to/pd actual=%b%b%b%b expected=%b%b%b%b", req,
               sys_rst_o, wake_o, to_flag_o, pd_flag_o, e_rst, e_wake, e_to, e_pd);
    end
  endtask

  // Called at a negedge; applies inputs for one posedge and returns at the next negedge.
  task automatic drive(input logic t, input logic c, input logic a, input logic b,
                       input logic h);
    tick_i = t; clr_i = c; clr_a_i = a; clr_b_i = b; halt_i = h;
    @(negedge clk);
    tick_i = 1'b0; clr_i = 1'b0; clr_a_i = 1'b0; clr_b_i = 1'b0; halt_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    dual_mode_i = mode;
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R1 reset state", 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_period;
    do_reset(1'b0);
    for (int i = 0; i < PERIOD - 1; i++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      if (i % 3 == 0) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    expect_out("R2 no timeout before last tick", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1);
    expect_out("R3 timeout pulse and TO", 1'b1, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 pulse one cycle", 1'b0, 1'b0, 1'b1, 1'b0);
    ticks(PERIOD - 1);
    expect_out("R3 restart full period", 1'b0, 1'b0, 1'b1, 1'b0);
    ticks(1);
    expect_out("R3 second timeout", 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_single_clear;
    do_reset(1'b0);
    ticks(100);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    ticks(27);
    expect_out("R4 halves ignored in single mode", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1);
    expect_out("R4 timeout despite halves", 1'b1, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R4 plain clear clears TO", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(PERIOD - 1);
    expect_out("R4 clear restarts count", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1);
    expect_out("R4 timeout after clear", 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_halt;
    do_reset(1'b0);
    ticks(100);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out("R7 halt flags", 1'b0, 1'b0, 1'b0, 1'b1);
    ticks(PERIOD - 1);
    expect_out("R7 halt restarts count", 1'b0, 1'b0, 1'b0, 1'b1);
    ticks(1);
    expect_out("R8 wake on halted timeout", 1'b0, 1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R8 wake one cycle", 1'b0, 1'b0, 1'b1, 1'b1);
    ticks(PERIOD);
    expect_out("R3 running timeout keeps PD", 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_priority;
    do_reset(1'b0);
    ticks(PERIOD - 1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R9 clear beats expiry", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(PERIOD - 1);
    expect_out("R9 full period after", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1);
    expect_out("R9 timeout afterwards", 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_dual_order;
    do_reset(1'b1);
    ticks(100);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    ticks(27);
    expect_out("R5 plain clear ignored", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1);
    expect_out("R5 timeout despite plain clear", 1'b1, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R6 lone B keeps TO", 1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 B then A clears", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(PERIOD);
    expect_out("R5 timeout after pair", 1'b1, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    ticks(60);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R5 A then B clears after 60 ticks", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(PERIOD - 1);
    expect_out("R5 pair restarted count", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1);
    expect_out("R5 timeout one period after pair", 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_dual_repeat;
    do_reset(1'b1);
    ticks(100);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    ticks(20);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    ticks(7);
    expect_out("R6 repeated A no restart", 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(1);
    expect_out("R6 timeout despite A repeats", 1'b1, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R6 A held, TO unchanged", 1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R6 held A completes with B", 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out("R7 halt in paired mode", 1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R5 pair clears PD", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: run hung, actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_period();
    t_single_clear();
    t_halt();
    t_priority();
    t_dual_order();
    t_dual_repeat();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule